// File: doc/BRIEF.md
# Three-Wire Serial Bus Slave

This block is the slave end of a three-wire serial link. The link has an active-low select, a bus clock and one bidirectional data wire. A frame opens with a 9-bit header that carries a device code, a direction flag and a register index. A 16-bit data word follows. Bits travel most significant first, one bit on each rising bus-clock edge while select is low. The block samples all three wires into its own system clock. It turns each frame into accesses on a parallel port toward a local register file. That port carries the register index, write data, a one-cycle write strobe, a one-cycle read strobe and read data.

A read fetches its register as soon as the header is complete, and the fetched word then goes back on the data wire. A write commits only after all 16 data bits have arrived. A frame whose device code is not the configured one still passes through the bit count, so the frame after it is framed correctly. Such a frame never drives the data wire and raises no strobe. The block drives its data pin through a separate output enable.

Top module: `tw_bus_slave`

## Requirements
- R1: After reset, `bus_dat_oe`, `reg_wr` and `reg_rd` are all 0.
- R2: The header is 9 bits, received MSB first. Header bits 8:6 are the device code, bit 5 is the direction (1 = read, 0 = write) and bits 4:0 are the register index. On a matching frame, `reg_idx` carries that index for the rest of the frame.
- R3: On a matching write, the 16 data bits are received MSB first. After the 16th rising edge, `reg_wr` pulses for exactly one system clock, and `reg_wdata` then holds the assembled word.
- R4: On a matching read, `reg_rd` pulses for exactly one system clock shortly after the 9th header bit, before the first data edge. `reg_rdata` is sampled during that pulse.
- R5: During a matching read's data phase, `bus_dat_oe` is 1. On each rising bus edge, `bus_dat_o` moves to the next bit of the fetched word, MSB first.
- R6: A frame whose device code differs from `DEV_ID` raises no strobe and never asserts `bus_dat_oe`. Its 25 bits are still counted, so a following frame in the same selection decodes normally.
- R7: After 25 bits the engine returns to the header phase without select being released, so frames can follow one another back to back.
- R8: Raising `bus_sel_n` in mid-frame abandons the frame without a strobe and clears `bus_dat_oe`. The next selection starts afresh at header bit 8.
- R9: Bus clock edges while `bus_sel_n` is high are ignored: they raise no strobe and shift no bit.
- R10: After the last bit of a read, `bus_dat_oe` stays 1 until the next rising bus edge or until select is released, and then drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_clk | input | 1 | Bus clock; bits move on its rising edge |
| bus_dat_i | input | 1 | Data wire as seen at the pin |
| bus_dat_o | output | 1 | Data value to drive onto the wire |
| bus_dat_oe | output | 1 | Output enable for the data pin |
| reg_idx | output | 5 | Register index of the current access |
| reg_wdata | output | 16 | Write data |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 16 | Read data, valid while `reg_rd` is high |

## Verification
The bench builds the block with its default widths (3-bit device code, 5-bit index, 16-bit word) and `DEV_ID` set to 5. Those widths are small enough to sweep every one of the 32 register indices through a write frame followed back to back by a read frame, with a distinct word per index. They also let every one of the eight device codes be tried, so all seven foreign codes are shown to stay silent. The small header also makes it cheap to abort frames part way through and to toggle the bus clock while deselected.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_WORD = 1'b1
  } tw_phase_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import tw_pkg::*;
#(
  parameter int          DEV_W  = 3,
  parameter int          IDX_W  = 5,
  parameter int          DATA_W = 16,
  parameter int          DEV_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              dat_s,
  output logic              dat_o,
  output logic              dat_oe,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] wdata,
  output logic              wr,
  output logic              rd,
  input  logic [DATA_W-1:0] rdata
);
  localparam int HDR_BITS = DEV_W + 1 + IDX_W;
  localparam int MAXB     = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int SH_W     = MAXB - 1;
  localparam int CNT_W    = $clog2(MAXB);
  localparam int RW_POS   = IDX_W;

  tw_phase_e         phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SH_W-1:0]   sh_q, sh_n;
  logic [DATA_W-1:0] out_q, out_n;
  logic              sclk_q, rise;
  logic              rdmode_q, rdmode_n;
  logic              match_q, match_n;
  logic              pend_q, pend_n;
  logic              tail_q, tail_n;
  logic              dat_o_n, oe_n, wr_n, rd_n;
  logic [IDX_W-1:0]  idx_n;
  logic [DATA_W-1:0] wdata_n;
  logic [HDR_BITS-1:0] hdr;

  assign rise = sclk_s & ~sclk_q;
  assign hdr  = {sh_q[HDR_BITS-2:0], dat_s};

  always_comb begin
    phase_n  = phase_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    out_n    = out_q;
    rdmode_n = rdmode_q;
    match_n  = match_q;
    pend_n   = pend_q;
    tail_n   = tail_q;
    dat_o_n  = dat_o;
    oe_n     = dat_oe;
    idx_n    = idx;
    wdata_n  = wdata;
    wr_n     = 1'b0;
    rd_n     = 1'b0;
    if (sel_s) begin
      phase_n = PH_HDR;
      cnt_n   = CNT_W'(HDR_BITS - 1);
      sh_n    = '0;
      match_n = 1'b0;
      pend_n  = 1'b0;
      tail_n  = 1'b0;
      oe_n    = 1'b0;
      dat_o_n = 1'b0;
    end else begin
      if (pend_q) begin
        rd_n   = 1'b1;
        pend_n = 1'b0;
      end
      if (rd) out_n = rdata;
      if (rise) begin
        if (tail_q) begin
          tail_n = 1'b0;
          oe_n   = 1'b0;
        end
        if (phase_q == PH_HDR) begin
          sh_n = {sh_q[SH_W-2:0], dat_s};
          if (cnt_q == '0) begin
            match_n  = (hdr[HDR_BITS-1 -: DEV_W] == DEV_W'(DEV_ID));
            rdmode_n = hdr[RW_POS];
            phase_n  = PH_WORD;
            cnt_n    = CNT_W'(DATA_W - 1);
            sh_n     = '0;
            dat_o_n  = 1'b0;
            if (hdr[HDR_BITS-1 -: DEV_W] == DEV_W'(DEV_ID)) begin
              idx_n = hdr[IDX_W-1:0];
              if (hdr[RW_POS]) begin
                pend_n = 1'b1;
                oe_n   = 1'b1;
              end
            end
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end else begin
          if (rdmode_q) begin
            dat_o_n = out_q[DATA_W-1];
            out_n   = {out_q[DATA_W-2:0], 1'b0};
          end else begin
            sh_n = {sh_q[SH_W-2:0], dat_s};
          end
          if (cnt_q == '0) begin
            phase_n = PH_HDR;
            cnt_n   = CNT_W'(HDR_BITS - 1);
            sh_n    = '0;
            if (match_q && !rdmode_q) begin
              wr_n    = 1'b1;
              wdata_n = {sh_q[DATA_W-2:0], dat_s};
            end
            if (match_q && rdmode_q) tail_n = 1'b1;
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HDR;
      cnt_q    <= CNT_W'(HDR_BITS - 1);
      sh_q     <= '0;
      out_q    <= '0;
      sclk_q   <= 1'b0;
      rdmode_q <= 1'b0;
      match_q  <= 1'b0;
      pend_q   <= 1'b0;
      tail_q   <= 1'b0;
      dat_o    <= 1'b0;
      dat_oe   <= 1'b0;
      idx      <= '0;
      wdata    <= '0;
      wr       <= 1'b0;
      rd       <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      out_q    <= out_n;
      sclk_q   <= sclk_s;
      rdmode_q <= rdmode_n;
      match_q  <= match_n;
      pend_q   <= pend_n;
      tail_q   <= tail_n;
      dat_o    <= dat_o_n;
      dat_oe   <= oe_n;
      idx      <= idx_n;
      wdata    <= wdata_n;
      wr       <= wr_n;
      rd       <= rd_n;
    end
  end
endmodule

// File: rtl/tw_bus_slave.sv
module tw_bus_slave #(
  parameter int DEV_W       = 3,
  parameter int IDX_W       = 5,
  parameter int DATA_W      = 16,
  parameter int DEV_ID      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_clk,
  input  logic              bus_dat_i,
  output logic              bus_dat_o,
  output logic              bus_dat_oe,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pins_s;

  tw_sync #(
    .W       (NPIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_sel_n, bus_clk, bus_dat_i}),
    .q     (pins_s)
  );

  tw_engine #(
    .DEV_W  (DEV_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W),
    .DEV_ID (DEV_ID)
  ) i_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_s  (pins_s[2]),
    .sclk_s (pins_s[1]),
    .dat_s  (pins_s[0]),
    .dat_o  (bus_dat_o),
    .dat_oe (bus_dat_oe),
    .idx    (reg_idx),
    .wdata  (reg_wdata),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .rdata  (reg_rdata)
  );
endmodule

// File: rtl/tw_bus_slave_chk.sv
module tw_bus_slave_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel_n,
  input logic             bus_dat_oe,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [IDX_W-1:0] reg_idx
);
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_wr_rd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_wr_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !bus_dat_oe);

  p_wr_idx_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $stable(reg_idx));

  p_oe_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_n && $past(bus_sel_n) && $past(bus_sel_n, 2) && $past(bus_sel_n, 3))
      |-> !bus_dat_oe);
endmodule

bind tw_bus_slave tw_bus_slave_chk #(.IDX_W(IDX_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel_n  (bus_sel_n),
  .bus_dat_oe (bus_dat_oe),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_idx    (reg_idx)
);

// File: tb/test_tw_bus_slave.sv
module test_tw_bus_slave;
  localparam int MY_ID = 5;
  localparam int HP    = 6;

  logic        clk, rst_n;
  logic        bus_sel_n, bus_clk, bus_dat_i;
  logic        bus_dat_o, bus_dat_oe;
  logic [4:0]  reg_idx;
  logic [15:0] reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [4:0]  wr_idx, rd_idx;
  logic [15:0] wr_data;

  tw_bus_slave #(.DEV_ID(MY_ID)) i_tw_bus_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel_n  (bus_sel_n),
    .bus_clk    (bus_clk),
    .bus_dat_i  (bus_dat_i),
    .bus_dat_o  (bus_dat_o),
    .bus_dat_oe (bus_dat_oe),
    .reg_idx    (reg_idx),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] rd_pat(input logic [4:0] i);
    return {i, ~i, i, i[0]} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] wr_pat(input logic [4:0] i);
    return {~i, i[2:0], i, i[4:2]} ^ 16'hC391;
  endfunction

  assign reg_rdata = rd_pat(reg_idx);

  always @(posedge clk) begin
    if (reg_wr) begin
      wr_cnt  <= wr_cnt + 1;
      wr_idx  <= reg_idx;
      wr_data <= reg_wdata;
    end
    if (reg_rd) begin
      rd_cnt <= rd_cnt + 1;
      rd_idx <= reg_idx;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic d, output logic so, output logic soe);
    @(negedge clk);
    bus_clk   = 1'b0;
    bus_dat_i = d;
    repeat (HP) @(negedge clk);
    bus_clk = 1'b1;
    repeat (HP) @(negedge clk);
    so  = bus_dat_o;
    soe = bus_dat_oe;
  endtask

  task automatic frame(input logic [2:0] dev, input logic rw, input logic [4:0] idx,
                       input logic [15:0] wd, output logic [15:0] bits,
                       output logic oe_all, output logic oe_hdr);
    logic [8:0] h;
    logic o, e;
    h      = {dev, rw, idx};
    oe_all = 1'b1;
    oe_hdr = 1'b0;
    for (int i = 8; i >= 0; i--) begin
      tick(h[i], o, e);
      if (i != 0) oe_hdr |= e;
    end
    for (int i = 15; i >= 0; i--) begin
      tick(rw ? 1'b0 : wd[i], o, e);
      bits[i] = o;
      oe_all &= e;
    end
  endtask

  task automatic select(input logic v);
    @(negedge clk);
    bus_sel_n = v;
    repeat (HP) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] bits;
    logic oa, oh, o, e;
    int w0, r0;
    rst_n = 1'b0; bus_sel_n = 1'b1; bus_clk = 1'b0; bus_dat_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 oe", bus_dat_oe, 0);
    check("R1 wr", reg_wr, 0);
    check("R1 rd", reg_rd, 0);

    // R2 R3 R4 R5 R7 R10: write then read every index back to back
    for (int i = 0; i < 32; i++) begin
      select(1'b0);
      w0 = wr_cnt; r0 = rd_cnt;
      frame(3'(MY_ID), 1'b0, 5'(i), wr_pat(5'(i)), bits, oa, oh);
      check("R3 one write strobe", wr_cnt - w0, 1);
      check("R2 write index", wr_idx, i);
      check("R3 write data", wr_data, wr_pat(5'(i)));
      check("R3 no read strobe", rd_cnt - r0, 0);
      frame(3'(MY_ID), 1'b1, 5'(i), 16'h0, bits, oa, oh);
      check("R4 one read strobe", rd_cnt - r0, 1);
      check("R4 read index", rd_idx, i);
      check("R5 read bits", bits, rd_pat(5'(i)));
      check("R5 oe in data phase", oa, 1);
      check("R7 write count after read", wr_cnt - w0, 1);
      check("R10 oe held after last bit", bus_dat_oe, 1);
      if (i % 2 == 0) begin
        tick(1'b0, o, e);
        check("R10 oe dropped on next edge", e, 0);
      end
      select(1'b1);
      check("R10 oe dropped on release", bus_dat_oe, 0);
    end

    // R6: foreign device codes
    select(1'b0);
    for (int d = 0; d < 8; d++) begin
      if (d != MY_ID) begin
        w0 = wr_cnt; r0 = rd_cnt;
        frame(3'(d), 1'b0, 5'(d + 3), 16'hFFFF, bits, oa, oh);
        frame(3'(d), 1'b1, 5'(d + 9), 16'h0, bits, oa, oh);
        check("R6 no strobe for foreign code", (wr_cnt - w0) + (rd_cnt - r0), 0);
        check("R6 oe never driven", oa | oh, 0);
      end
    end
    w0 = wr_cnt;
    frame(3'(MY_ID), 1'b0, 5'd17, 16'hB00F, bits, oa, oh);
    check("R6 following frame still framed", wr_cnt - w0, 1);
    check("R6 following frame data", wr_data, 16'hB00F);
    select(1'b1);

    // R8: abort mid-header and mid-read
    select(1'b0);
    w0 = wr_cnt; r0 = rd_cnt;
    for (int k = 0; k < 5; k++) tick(1'b1, o, e);
    select(1'b1);
    select(1'b0);
    frame(3'(MY_ID), 1'b0, 5'd9, 16'h1234, bits, oa, oh);
    check("R8 restart after header abort", wr_cnt - w0, 1);
    check("R8 restart index", wr_idx, 9);
    check("R8 restart data", wr_data, 16'h1234);
    begin
      logic [8:0] h;
      h = {3'(MY_ID), 1'b1, 5'd4};
      for (int k = 8; k >= 0; k--) tick(h[k], o, e);
      for (int k = 0; k < 3; k++) tick(1'b0, o, e);
      check("R8 oe during aborted read", e, 1);
    end
    select(1'b1);
    check("R8 oe cleared by release", bus_dat_oe, 0);

    // R9: bus clocks while deselected
    w0 = wr_cnt; r0 = rd_cnt;
    begin
      logic [24:0] junk;
      junk = {3'(MY_ID), 1'b0, 5'd2, 16'hFFFF};
      for (int k = 24; k >= 0; k--) tick(junk[k], o, e);
    end
    check("R9 deselected edges raise no strobe", (wr_cnt - w0) + (rd_cnt - r0), 0);
    select(1'b0);
    frame(3'(MY_ID), 1'b0, 5'd30, 16'h0F0F, bits, oa, oh);
    check("R9 no stale bits shifted", wr_cnt - w0, 1);
    check("R9 frame index", wr_idx, 30);
    check("R9 frame data", wr_data, 16'h0F0F);
    select(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule